// File: doc/BRIEF.md
# Motor Drive Fault Supervisor

This block sits next to a motor inverter controller and watches three fault sources: an overcurrent comparator, a DC-bus overvoltage comparator, and a strobe that pulses whenever the serial link shows activity. Overcurrent and overvoltage events are held in hardware latches. While either latch is set, a drive-kill output forces the gate drivers off. A missing activity strobe raises a communication timeout. The timeout does not latch and clears by itself once activity returns.

The fault state is reported three ways: a three-bit alarm field with one bit per fault class, a red indicator that stays lit while the overcurrent latch is set, and a yellow indicator that blinks at a slow, prescaled rate during a communication timeout. The latches can be cleared only through an active-low clear pin. That pin must be held low without a break for a qualified time, three seconds by default, counted in clock cycles. All asynchronous inputs pass through two-flop synchronizers before any logic uses them.

Top module: `drive_fault_supervisor`

## Requirements
- R1: An overcurrent input that is high on a sampled clock edge sets the overcurrent latch. The latch drives alarm bit 0 and keeps `led_red` steadily on for as long as it is set.
- R2: An overvoltage input that is high on a sampled clock edge sets the overvoltage latch. The latch drives alarm bit 2, so that fault on its own reads as alarm value 0x04.
- R3: When COMM_LIMIT cycles pass with no synchronized activity strobe, alarm bit 1 is set. It clears within a few cycles after a strobe arrives.
- R4: During a communication timeout, `led_yellow` alternates, staying high and low for CLK_HZ/(2*BLINK_HZ) cycles each. With no timeout it stays low.
- R5: `drive_off` is high whenever either latch is set and low once both latches are clear. A communication timeout alone does not raise it.
- R6: The latches clear only after `clr_n_pin` has been held low continuously for CLK_HZ*HOLD_SEC cycles. A shorter hold has no effect. A high level during the hold restarts the count from zero.
- R7: If a fault input is still active when the hold completes, its latch stays set.
- R8: A fault input that rises just before clock edge 1 appears on the alarm output after edge 3 and not after edge 2. Two of those edges are synchronizer stages and one is the latch.
- R9: While `rst_n` is low, and directly after it is released, the alarm field, both LEDs and `drive_off` are all zero.
- R10: Several faults are reported together. Overcurrent plus overvoltage reads as 0x05, and adding a timeout reads as 0x07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oc_in | input | 1 | Asynchronous overcurrent comparator, high = fault |
| ov_in | input | 1 | Asynchronous DC-bus overvoltage comparator, high = fault |
| comm_strobe | input | 1 | Asynchronous link activity pulse |
| clr_n_pin | input | 1 | Asynchronous fault-clear pin, active low, must be held |
| alarm_code | output | 3 | Bit 0 overcurrent latch, bit 1 communication timeout, bit 2 overvoltage latch |
| led_red | output | 1 | Steady red indicator for the overcurrent latch |
| led_yellow | output | 1 | Blinking yellow indicator for communication timeout |
| drive_off | output | 1 | Forces the gate drivers off while any latch is set |

## Verification
The hardest situation to reach from the ports is a clear hold that completes while a fault input is still active. Close behind it is a hold that adds up to more than the qualified time but was broken by a brief high level. The bench builds both on purpose by holding `clr_n_pin` low for exact cycle counts around the threshold. It then runs a seeded random sequence of fault pulses and clear holds of mixed length, with the activity strobe arriving at random gaps, and compares the alarm field against a bench model of the latches.

// File: rtl/drv_fault_pkg.sv
// Shared fault-class indices and vector type for the fault supervisor.
// Assumes three fault classes. The alarm bit order is fixed here.
package drv_fault_pkg;
    localparam int FB_OC   = 0;
    localparam int FB_COMM = 1;
    localparam int FB_OV   = 2;
    localparam int NFAULT  = 3;
    typedef logic [NFAULT-1:0] fault_vec_t;
endpackage

// File: rtl/fs_sync2.sv
// Two-flop synchronizer bank, one chain per bit.
// Assumes every input bit is asynchronous to clk. RST_VAL sets each bit's idle level.
module fs_sync2 #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        // Two-stage capture of one asynchronous bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta <= RST_VAL[i];
                q[i] <= RST_VAL[i];
            end else begin
                meta <= d[i];
                q[i] <= meta;
            end
        end
    end
endmodule

// File: rtl/fs_comm_wdog.sv
// Counts cycles since the last activity strobe and flags a timeout at LIMIT.
// Assumes strobe is already synchronized. The count saturates, so the flag holds until the next strobe.
module fs_comm_wdog #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic timeout
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    // Restart on activity, otherwise count up to the limit and stop there
    always_ff @(posedge clk) begin
        if (!rst_n || strobe)
            cnt <= '0;
        else if (cnt != CW'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign timeout = (cnt == CW'(LIMIT));
endmodule

// File: rtl/fs_blink.sv
// Prescaler that toggles a blink phase every HALF cycles.
// Assumes HALF >= 1. The phase runs freely and the consumer gates it.
module fs_blink #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int PW = $clog2(HALF + 1);
    logic [PW-1:0] pre;

    // Divide the clock down and flip the phase at each wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre   <= '0;
            phase <= 1'b0;
        end else if (pre == PW'(HALF - 1)) begin
            pre   <= '0;
            phase <= ~phase;
        end else begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/fs_clr_qual.sv
// Qualifies the active-low clear pin. Emits one pulse after HOLD cycles of continuous low.
// Assumes pin_n is synchronized. Any high level restarts the count, and holding the pin
// low past the threshold gives no second pulse.
module fs_clr_qual #(
    parameter int HOLD = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pulse
);
    localparam int HW = $clog2(HOLD + 1);
    logic [HW-1:0] cnt;

    // Count the continuous low time and fire once at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n || pin_n) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            if (cnt != HW'(HOLD))
                cnt <= cnt + 1'b1;
            pulse <= (cnt == HW'(HOLD - 1));
        end
    end
endmodule

// File: rtl/drive_fault_supervisor.sv
// Top of the motor drive fault supervisor.
// Synchronizes the inputs, latches overcurrent and overvoltage, runs the link watchdog,
// and drives the alarm field, the LEDs and the gate-kill output.
// Assumes clk runs at CLK_HZ. A latch clears only on a qualified clear pulse
// while its fault input is no longer active.
module drive_fault_supervisor
    import drv_fault_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int BLINK_HZ   = 2,
    parameter int HOLD_SEC   = 3,
    parameter int COMM_LIMIT = 5_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oc_in,
    input  logic       ov_in,
    input  logic       comm_strobe,
    input  logic       clr_n_pin,
    output logic [2:0] alarm_code,
    output logic       led_red,
    output logic       led_yellow,
    output logic       drive_off
);
    localparam int HOLD_CYCLES = CLK_HZ * HOLD_SEC;
    localparam int BLINK_HALF  = CLK_HZ / (2 * BLINK_HZ);

    logic [3:0] raw_in, syn_in;
    logic       oc_s, ov_s, strobe_s, clr_s;
    logic       clr_pulse, comm_to, blink_ph;
    logic       oc_lat, ov_lat;

    assign raw_in = {clr_n_pin, comm_strobe, ov_in, oc_in};

    fs_sync2 #(.W(4), .RST_VAL(4'b1000)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
    );
    assign {clr_s, strobe_s, ov_s, oc_s} = syn_in;

    fs_comm_wdog #(.LIMIT(COMM_LIMIT)) u_wdog (
        .clk(clk), .rst_n(rst_n), .strobe(strobe_s), .timeout(comm_to)
    );

    fs_blink #(.HALF(BLINK_HALF)) u_blink (
        .clk(clk), .rst_n(rst_n), .phase(blink_ph)
    );

    fs_clr_qual #(.HOLD(HOLD_CYCLES)) u_clr (
        .clk(clk), .rst_n(rst_n), .pin_n(clr_s), .pulse(clr_pulse)
    );

    // Hold each fault until a qualified clear arrives while the fault is gone
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_lat <= 1'b0;
            ov_lat <= 1'b0;
        end else begin
            oc_lat <= (oc_lat & ~clr_pulse) | oc_s;
            ov_lat <= (ov_lat & ~clr_pulse) | ov_s;
        end
    end

    // Assemble the alarm field and the indicator outputs
    always_comb begin
        alarm_code          = '0;
        alarm_code[FB_OC]   = oc_lat;
        alarm_code[FB_COMM] = comm_to;
        alarm_code[FB_OV]   = ov_lat;
        led_red             = oc_lat;
        led_yellow          = comm_to & blink_ph;
        drive_off           = oc_lat | ov_lat;
    end
endmodule

// File: rtl/drive_fault_sva.sv
// Checker for the fault supervisor, bound into the top module.
// Assumes the alarm bit order from drv_fault_pkg.
module drive_fault_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] alarm_code,
    input logic       led_red,
    input logic       led_yellow,
    input logic       drive_off,
    input logic       clr_pulse,
    input logic       oc_s
);
    // R1: the red LED follows the overcurrent bit of the alarm field
    a_r1_red_steady: assert property (@(posedge clk) disable iff (!rst_n)
        led_red == alarm_code[0]);

    // R4: the yellow LED never lights without a communication timeout
    a_r4_yellow_gated: assert property (@(posedge clk) disable iff (!rst_n)
        led_yellow |-> alarm_code[1]);

    // R5: a newly set latch kills the drive in the same cycle
    a_r5_kill_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(alarm_code[0]) || $rose(alarm_code[2])) |-> drive_off);

    // R6: a latch drops only right after a qualified clear pulse
    a_r6_clear_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(alarm_code[0]) || $fell(alarm_code[2])) |-> $past(clr_pulse));

    // R7: an overcurrent still active during the clear keeps the latch set
    a_r7_fault_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && oc_s) |=> alarm_code[0]);
endmodule

bind drive_fault_supervisor drive_fault_sva u_sva (
    .clk(clk), .rst_n(rst_n), .alarm_code(alarm_code), .led_red(led_red),
    .led_yellow(led_yellow), .drive_off(drive_off), .clr_pulse(clr_pulse), .oc_s(oc_s)
);

// File: tb/sim_drive_fault_supervisor.sv
// Bench: directed corner cases, then a seeded random sequence compared with a bench model.
module sim_drive_fault_supervisor;
    localparam int CLK_HZ = 40, BLINK_HZ = 2, HOLD_SEC = 3, LIMIT = 50;
    localparam int HOLD = CLK_HZ * HOLD_SEC;
    localparam int HALF = CLK_HZ / (2 * BLINK_HZ);

    logic clk = 1'b0, rst_n = 1'b0;
    logic oc_in = 1'b0, ov_in = 1'b0, comm_strobe = 1'b0, clr_n_pin = 1'b1;
    logic [2:0] alarm_code;
    logic led_red, led_yellow, drive_off;
    logic comm_en = 1'b1;
    int n_chk = 0, n_fail = 0;
    logic m_oc = 1'b0, m_ov = 1'b0;

    always #2 clk = ~clk;

    drive_fault_supervisor #(.CLK_HZ(CLK_HZ), .BLINK_HZ(BLINK_HZ), .HOLD_SEC(HOLD_SEC),
                             .COMM_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .oc_in(oc_in), .ov_in(ov_in), .comm_strobe(comm_strobe),
        .clr_n_pin(clr_n_pin), .alarm_code(alarm_code), .led_red(led_red),
        .led_yellow(led_yellow), .drive_off(drive_off)
    );

    function automatic logic [2:0] exp_alarm(logic oc, logic to, logic ov);
        return {ov, to, oc};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hold_clear(int n);
        clr_n_pin = 1'b0;
        step(n);
        clr_n_pin = 1'b1;
        step(6);
    endtask

    // Activity strobe source with random gaps, well inside the watchdog limit
    initial begin
        int gap = 3;
        forever begin
            @(negedge clk);
            comm_strobe = 1'b0;
            if (comm_en) begin
                gap--;
                if (gap <= 0) begin
                    comm_strobe = 1'b1;
                    gap = int'($urandom % 20) + 1;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        step(4);
        check("R9 alarm in reset", 32'(alarm_code), 0);
        check("R9 drive_off in reset", 32'(drive_off), 0);
        rst_n = 1'b1;
        step(2);
        check("R9 outputs after reset", 32'({alarm_code, led_red, led_yellow, drive_off}), 0);

        // R8 latency: input rises before edge 1, alarm appears after edge 3
        oc_in = 1'b1;
        step(2);
        check("R8 not after edge 2", 32'(alarm_code[0]), 0);
        step(1);
        check("R8 set after edge 3", 32'(alarm_code[0]), 1);
        oc_in = 1'b0;
        step(10);
        check("R1 latch held", 32'(alarm_code), 32'(exp_alarm(1, 0, 0)));
        check("R1 red steady", 32'(led_red), 1);
        check("R5 drive_off on oc", 32'(drive_off), 1);

        // R6 short hold, and a broken hold whose total exceeds the threshold
        hold_clear(HOLD - 10);
        check("R6 short hold ignored", 32'(alarm_code[0]), 1);
        clr_n_pin = 1'b0; step(HOLD - 20); clr_n_pin = 1'b1; step(3);
        clr_n_pin = 1'b0; step(HOLD - 20); clr_n_pin = 1'b1; step(6);
        check("R6 broken hold restarts", 32'(alarm_code[0]), 1);
        hold_clear(HOLD + 10);
        check("R6 full hold clears", 32'(alarm_code), 0);
        check("R5 drive_off released", 32'(drive_off), 0);
        check("R1 red off after clear", 32'(led_red), 0);

        // R2 overvoltage alone reads 0x04
        ov_in = 1'b1; step(5); ov_in = 1'b0; step(2);
        check("R2 ov code", 32'(alarm_code), 32'h4);
        check("R5 drive_off on ov", 32'(drive_off), 1);

        // R7 fault still active at hold completion
        oc_in = 1'b1;
        hold_clear(HOLD + 10);
        check("R7 active oc survives", 32'(alarm_code[0]), 1);
        check("R7 ov cleared", 32'(alarm_code[2]), 0);
        oc_in = 1'b0;
        hold_clear(HOLD + 10);
        check("R7 clears once gone", 32'(alarm_code), 0);

        // R3 and R4 communication timeout with blinking yellow
        check("R4 yellow off without timeout", 32'(led_yellow), 0);
        comm_enable_off();
        step(LIMIT + 10);
        check("R3 timeout flagged", 32'(alarm_code), 32'(exp_alarm(0, 1, 0)));
        check("R5 timeout alone no kill", 32'(drive_off), 0);
        begin
            int hi = 0;
            while (led_yellow !== 1'b0) step(1);
            while (led_yellow !== 1'b1) step(1);
            while (led_yellow === 1'b1) begin hi++; step(1); end
            check("R4 yellow high time", 32'(hi), 32'(HALF));
        end
        oc_in = 1'b1; ov_in = 1'b1; step(5); oc_in = 1'b0; ov_in = 1'b0;
        check("R10 all three", 32'(alarm_code), 32'h7);
        comm_en = 1'b1;
        step(30);
        check("R3 timeout clears", 32'(alarm_code[1]), 0);
        check("R10 oc plus ov", 32'(alarm_code), 32'h5);
        check("R4 yellow off after resume", 32'(led_yellow), 0);
        hold_clear(HOLD + 10);
        check("R6 both cleared", 32'(alarm_code), 0);

        // Seeded random sequence against the bench latch model
        for (int i = 0; i < 120; i++) begin
            int sel = int'($urandom % 4);
            if (sel == 0) begin
                oc_in = 1'b1; step(1); oc_in = 1'b0; step(5); m_oc = 1'b1;
            end else if (sel == 1) begin
                ov_in = 1'b1; step(1); ov_in = 1'b0; step(5); m_ov = 1'b1;
            end else if (sel == 2) begin
                hold_clear(int'($urandom % (HOLD - 10)) + 1);
            end else begin
                hold_clear(HOLD + 5 + int'($urandom % 20));
                m_oc = 1'b0; m_ov = 1'b0;
            end
            check("R10 random alarm match", 32'(alarm_code), 32'(exp_alarm(m_oc, 0, m_ov)));
        end
        check("R5 random drive_off", 32'(drive_off), 32'(m_oc | m_ov));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic comm_enable_off();
        comm_en = 1'b0;
    endtask
endmodule